// File: doc/BRIEF.md
# Doppler DC Notch Filter

This block is a streaming filter that sits between the output of a Doppler FFT and the input of a detection stage. Each incoming complex sample (signed I and Q) carries two tags: a Doppler bin index and a range bin index. The block forces I and Q to zero for every sample whose Doppler bin lies within a programmable distance of zero Doppler. All other samples pass through bit-exact. Its job is to remove stationary clutter that is still present after slow-time pulse cancellation.

The Doppler bins arrive in natural FFT order, with N = 32 bins by default. Bin 0 is zero Doppler, and negative frequencies occupy the upper indices. A notch half-width w therefore covers bins 0..w and also N-w..N-1, so the band wraps across the end of the index range. The width comes from a host configuration input. The block takes a new value only at the start of a frame, so every frame is notched consistently. Blanked samples are still emitted, which keeps the sample count, ordering and tags unchanged for the downstream stage.

Top module: `dc_notch`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle with `out_valid` high on the next clock, and a cycle with `in_valid` low produces `out_valid` low on the next clock.
- R2: `out_dop_bin` and `out_rng_bin` equal the Doppler and range tags of the sample that produced the output, one clock earlier.
- R3: With an effective notch width of 0, every sample leaves with I and Q unchanged.
- R4: With an effective width w in 1..N/2-1, a sample whose Doppler bin b satisfies b <= w or b >= N-w leaves with I = 0 and Q = 0 (N = 32, so w = 3 blanks bins 0..3 and 29..31).
- R5: With an effective width w in 1..N/2-1, a sample whose Doppler bin satisfies w < b < N-w leaves with I and Q bit-exact, including the extreme values -32768 and +32767.
- R6: An effective width of N/2 (16) or more blanks every Doppler bin.
- R7: The effective width is captured from `notch_width_cfg` on a frame-start sample, which is a valid sample with Doppler bin 0 and range bin 0. That capture applies to the frame-start sample itself and to every later sample. Changes to `notch_width_cfg` at any other time have no effect until the next frame start.
- R8: A clock edge with `rst_n` low sets `out_valid` to 0, sets `out_i` and `out_q` to 0, and sets the effective width to 0, so samples after reset and before the first frame start pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| notch_width_cfg | input | CFG_W (6) | Host-written notch half-width, in bins |
| in_valid | input | 1 | Input sample valid |
| in_i | input | DATA_W (16) | Input in-phase sample, signed |
| in_q | input | DATA_W (16) | Input quadrature sample, signed |
| in_dop_bin | input | log2(DOP_BINS) (5) | Doppler bin index of the input sample |
| in_rng_bin | input | log2(RNG_BINS) (6) | Range bin index of the input sample |
| out_valid | output | 1 | Output sample valid |
| out_i | output | DATA_W (16) | Output in-phase sample, signed |
| out_q | output | DATA_W (16) | Output quadrature sample, signed |
| out_dop_bin | output | log2(DOP_BINS) (5) | Forwarded Doppler bin index |
| out_rng_bin | output | log2(RNG_BINS) (6) | Forwarded range bin index |

## Verification
The only internal state is the held notch width. If it is wrong, the outputs show it one clock after the first non-frame-start sample whose bin is near the notch edge: either a sample near DC appears with non-zero data, or a sample just outside the band appears zeroed. The stimulus therefore sweeps complete Doppler rows for several widths, including the edge bins w, w+1, N-w-1 and N-w. It also changes the configuration in the middle of a frame. A fault in the output register or the tag path shows as a count, tag or data mismatch on the very next output cycle.

// File: rtl/dcn_pkg.sv
// Package: dcn_pkg
// Shared defaults and lane enumeration for the Doppler DC notch filter.
// Assumes: consumers derive their index widths from these defaults via $clog2.
package dcn_pkg;
    localparam int DEF_DATA_W   = 16;
    localparam int DEF_DOP_BINS = 32;
    localparam int DEF_RNG_BINS = 64;
    localparam int DEF_CFG_W    = 6;
    localparam int NUM_LANES    = 2;

    typedef enum logic {
        LANE_I = 1'b0,
        LANE_Q = 1'b1
    } lane_e;
endpackage

// File: rtl/dcn_width_hold.sv
// Module: dcn_width_hold
// Captures the host notch width at each frame start and clamps it to DOP_BINS/2.
// Assumes: a frame starts on the valid sample tagged Doppler 0, range 0; the
// captured value also applies to that frame-start sample itself.
module dcn_width_hold #(
    parameter int DOP_BINS = 32,
    parameter int RNG_BINS = 64,
    parameter int CFG_W    = 6,
    localparam int DOP_W   = $clog2(DOP_BINS),
    localparam int RNG_W   = $clog2(RNG_BINS),
    localparam int CMP_W   = (CFG_W > DOP_W + 1) ? CFG_W : DOP_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DOP_W-1:0] in_dop_bin,
    input  logic [RNG_W-1:0] in_rng_bin,
    input  logic [CFG_W-1:0] notch_width_cfg,
    output logic [CMP_W-1:0] eff_width
);
    localparam logic [CMP_W-1:0] HALF_V = CMP_W'(DOP_BINS / 2);

    logic             frame_start;
    logic [CMP_W-1:0] held_q;
    logic [CMP_W-1:0] cfg_clamped;
    logic [CMP_W-1:0] held_clamped;

    // Decode the frame-start sample.
    always_comb begin
        frame_start = in_valid && (in_dop_bin == '0) && (in_rng_bin == '0);
    end

    // Clamp both the fresh and the held value so that no index wraps.
    always_comb begin
        cfg_clamped  = (CMP_W'(notch_width_cfg) >= HALF_V) ? HALF_V : CMP_W'(notch_width_cfg);
        held_clamped = (held_q >= HALF_V) ? HALF_V : held_q;
    end

    // Hold the width for the rest of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (frame_start) begin
            held_q <= cfg_clamped;
        end
    end

    // The frame-start sample already uses the new width.
    always_comb begin
        eff_width = frame_start ? cfg_clamped : held_clamped;
    end
endmodule

// File: rtl/dcn_band_match.sv
// Module: dcn_band_match
// Decides whether a Doppler bin falls inside the wrapped notch band around DC.
// Assumes: width is already clamped to at most DOP_BINS/2; natural FFT order.
module dcn_band_match #(
    parameter int DOP_BINS = 32,
    parameter int CMP_W    = 6,
    localparam int DOP_W   = $clog2(DOP_BINS)
) (
    input  logic [DOP_W-1:0] dop_bin,
    input  logic [CMP_W-1:0] width,
    output logic             blank
);
    localparam logic [CMP_W-1:0] N_V    = CMP_W'(DOP_BINS);
    localparam logic [CMP_W-1:0] HALF_V = CMP_W'(DOP_BINS / 2);

    logic [CMP_W-1:0] bin_ext;
    logic [CMP_W-1:0] upper_edge;
    logic             in_low;
    logic             in_high;

    // Compare the bin against the positive and the wrapped negative edge.
    always_comb begin
        bin_ext    = CMP_W'(dop_bin);
        upper_edge = N_V - width;
        in_low     = (bin_ext <= width);
        in_high    = (bin_ext >= upper_edge);
        if (width == '0) begin
            blank = 1'b0;
        end else if (width >= HALF_V) begin
            blank = 1'b1;
        end else begin
            blank = in_low || in_high;
        end
    end
endmodule

// File: rtl/dcn_out_stage.sv
// Module: dcn_out_stage
// Single register stage that zeroes or forwards I/Q and forwards the bin tags.
// Assumes: one output per input valid; data and tags hold between valids.
module dcn_out_stage #(
    parameter int DATA_W = 16,
    parameter int DOP_W  = 5,
    parameter int RNG_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     blank,
    input  logic signed [DATA_W-1:0] lane_in  [dcn_pkg::NUM_LANES],
    input  logic [DOP_W-1:0]         in_dop_bin,
    input  logic [RNG_W-1:0]         in_rng_bin,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] lane_out [dcn_pkg::NUM_LANES],
    output logic [DOP_W-1:0]         out_dop_bin,
    output logic [RNG_W-1:0]         out_rng_bin
);
    // Register the valid flag every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Register the tags on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dop_bin <= '0;
            out_rng_bin <= '0;
        end else if (in_valid) begin
            out_dop_bin <= in_dop_bin;
            out_rng_bin <= in_rng_bin;
        end
    end

    for (genvar g = 0; g < dcn_pkg::NUM_LANES; g++) begin : g_lane
        // Register one data lane, zeroed when blanked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_out[g] <= '0;
            end else if (in_valid) begin
                lane_out[g] <= blank ? '0 : lane_in[g];
            end
        end
    end
endmodule

// File: rtl/dc_notch.sv
// Module: dc_notch
// Streaming Doppler DC notch: zeroes I/Q for bins within +/- width of DC,
// passes all other samples unchanged, and keeps the count and ordering of samples.
// Assumes: width is taken at frame start (Doppler 0, range 0); latency is one clock.
module dc_notch #(
    parameter int DATA_W   = dcn_pkg::DEF_DATA_W,
    parameter int DOP_BINS = dcn_pkg::DEF_DOP_BINS,
    parameter int RNG_BINS = dcn_pkg::DEF_RNG_BINS,
    parameter int CFG_W    = dcn_pkg::DEF_CFG_W,
    localparam int DOP_W   = $clog2(DOP_BINS),
    localparam int RNG_W   = $clog2(RNG_BINS),
    localparam int CMP_W   = (CFG_W > DOP_W + 1) ? CFG_W : DOP_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CFG_W-1:0]         notch_width_cfg,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic [DOP_W-1:0]         in_dop_bin,
    input  logic [RNG_W-1:0]         in_rng_bin,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_i,
    output logic signed [DATA_W-1:0] out_q,
    output logic [DOP_W-1:0]         out_dop_bin,
    output logic [RNG_W-1:0]         out_rng_bin
);
    logic [CMP_W-1:0]         eff_width;
    logic                     blank;
    logic signed [DATA_W-1:0] lanes_in  [dcn_pkg::NUM_LANES];
    logic signed [DATA_W-1:0] lanes_out [dcn_pkg::NUM_LANES];

    // Gather the I and Q inputs into lanes.
    always_comb begin
        lanes_in[dcn_pkg::LANE_I] = in_i;
        lanes_in[dcn_pkg::LANE_Q] = in_q;
    end

    dcn_width_hold #(
        .DOP_BINS (DOP_BINS),
        .RNG_BINS (RNG_BINS),
        .CFG_W    (CFG_W)
    ) u_width (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .in_dop_bin      (in_dop_bin),
        .in_rng_bin      (in_rng_bin),
        .notch_width_cfg (notch_width_cfg),
        .eff_width       (eff_width)
    );

    dcn_band_match #(
        .DOP_BINS (DOP_BINS),
        .CMP_W    (CMP_W)
    ) u_match (
        .dop_bin (in_dop_bin),
        .width   (eff_width),
        .blank   (blank)
    );

    dcn_out_stage #(
        .DATA_W (DATA_W),
        .DOP_W  (DOP_W),
        .RNG_W  (RNG_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .blank       (blank),
        .lane_in     (lanes_in),
        .in_dop_bin  (in_dop_bin),
        .in_rng_bin  (in_rng_bin),
        .out_valid   (out_valid),
        .lane_out    (lanes_out),
        .out_dop_bin (out_dop_bin),
        .out_rng_bin (out_rng_bin)
    );

    // Split the output lanes back into I and Q.
    always_comb begin
        out_i = lanes_out[dcn_pkg::LANE_I];
        out_q = lanes_out[dcn_pkg::LANE_Q];
    end
endmodule

// File: rtl/dc_notch_chk.sv
// Module: dc_notch_chk
// Port-level property checker for dc_notch, attached with bind.
// Assumes: keeps its own copy of the frame width, built from the port contract.
module dc_notch_chk #(
    parameter int DATA_W   = 16,
    parameter int DOP_BINS = 32,
    parameter int RNG_BINS = 64,
    parameter int CFG_W    = 6,
    localparam int DOP_W   = $clog2(DOP_BINS),
    localparam int RNG_W   = $clog2(RNG_BINS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CFG_W-1:0]         notch_width_cfg,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_i,
    input logic signed [DATA_W-1:0] in_q,
    input logic [DOP_W-1:0]         in_dop_bin,
    input logic [RNG_W-1:0]         in_rng_bin,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_i,
    input logic signed [DATA_W-1:0] out_q,
    input logic [DOP_W-1:0]         out_dop_bin,
    input logic [RNG_W-1:0]         out_rng_bin
);
    logic     fs;
    int       cur_w;
    int       held_w;
    logic     exp_blank;

    // Form the width that applies to the current input sample.
    always_comb begin
        fs        = in_valid && (in_dop_bin == '0) && (in_rng_bin == '0);
        cur_w     = fs ? int'(notch_width_cfg) : held_w;
        exp_blank = (cur_w != 0) &&
                    ((cur_w >= DOP_BINS / 2) ||
                     (int'(in_dop_bin) <= cur_w) ||
                     (int'(in_dop_bin) >= DOP_BINS - cur_w));
    end

    // Track the width captured at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_w <= 0;
        end else if (fs) begin
            held_w <= int'(notch_width_cfg);
        end
    end

    AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R1
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R1
    AST_TAGS_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dop_bin == $past(in_dop_bin)) && (out_rng_bin == $past(in_rng_bin)));  // R2
    AST_ZERO_WIDTH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_w == 0) |=> (out_i == $past(in_i)) && (out_q == $past(in_q)));  // R3
    AST_BAND_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && exp_blank) |=> (out_i == '0) && (out_q == '0));  // R4
    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !exp_blank) |=> (out_i == $past(in_i)) && (out_q == $past(in_q)));  // R5
    AST_WIDE_ALL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cur_w >= DOP_BINS / 2) |=> (out_i == '0) && (out_q == '0));  // R6
    AST_FRAME_START_DC: assert property (@(posedge clk) disable iff (!rst_n)
        (fs && notch_width_cfg != '0) |=> (out_i == '0) && (out_q == '0));  // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !out_valid && (out_i == '0) && (out_q == '0));  // R8
endmodule

bind dc_notch dc_notch_chk #(
    .DATA_W   (DATA_W),
    .DOP_BINS (DOP_BINS),
    .RNG_BINS (RNG_BINS),
    .CFG_W    (CFG_W)
) u_dc_notch_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .notch_width_cfg (notch_width_cfg),
    .in_valid        (in_valid),
    .in_i            (in_i),
    .in_q            (in_q),
    .in_dop_bin      (in_dop_bin),
    .in_rng_bin      (in_rng_bin),
    .out_valid       (out_valid),
    .out_i           (out_i),
    .out_q           (out_q),
    .out_dop_bin     (out_dop_bin),
    .out_rng_bin     (out_rng_bin)
);

// File: tb/dc_notch_bench.sv
// Bench: dc_notch_bench
// Directed scenarios, one task each; expected values come from the requirements.
module dc_notch_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int NB         = 32;
    localparam int DOP_W      = 5;
    localparam int RNG_W      = 6;
    localparam int CFG_W      = 6;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [CFG_W-1:0]         notch_width_cfg = '0;
    logic                     in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_i = '0;
    logic signed [DATA_W-1:0] in_q = '0;
    logic [DOP_W-1:0]         in_dop_bin = '0;
    logic [RNG_W-1:0]         in_rng_bin = '0;
    logic                     out_valid;
    logic signed [DATA_W-1:0] out_i;
    logic signed [DATA_W-1:0] out_q;
    logic [DOP_W-1:0]         out_dop_bin;
    logic [RNG_W-1:0]         out_rng_bin;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  model_w  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dc_notch u_dc_notch (
        .clk             (clk),
        .rst_n           (rst_n),
        .notch_width_cfg (notch_width_cfg),
        .in_valid        (in_valid),
        .in_i            (in_i),
        .in_q            (in_q),
        .in_dop_bin      (in_dop_bin),
        .in_rng_bin      (in_rng_bin),
        .out_valid       (out_valid),
        .out_i           (out_i),
        .out_q           (out_q),
        .out_dop_bin     (out_dop_bin),
        .out_rng_bin     (out_rng_bin)
    );

    function automatic bit band_hit(input int b, input int w);
        if (w == 0) return 1'b0;
        if (w >= NB / 2) return 1'b1;
        return (b <= w) || (b >= NB - w);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one sample, then check the registered output one clock later.
    task automatic send(input int dop, input int rng, input int iv, input int qv,
                        input int cfg, input string req);
        logic signed [DATA_W-1:0] ei;
        logic signed [DATA_W-1:0] eq;
        bit blank;
        @(negedge clk);
        notch_width_cfg = CFG_W'(cfg);
        in_valid   = 1'b1;
        in_dop_bin = DOP_W'(dop);
        in_rng_bin = RNG_W'(rng);
        in_i       = DATA_W'(iv);
        in_q       = DATA_W'(qv);
        if (dop == 0 && rng == 0) model_w = cfg;
        blank = band_hit(dop, model_w);
        ei = blank ? '0 : DATA_W'(iv);
        eq = blank ? '0 : DATA_W'(qv);
        @(posedge clk);
        #1;
        check(out_valid == 1'b1, "R1", "out_valid", longint'(out_valid), 1);
        check(out_dop_bin == DOP_W'(dop) && out_rng_bin == RNG_W'(rng), "R2", "tags",
              longint'({out_rng_bin, out_dop_bin}), longint'({RNG_W'(rng), DOP_W'(dop)}));
        check(out_i == ei && out_q == eq, req, "data I",
              longint'(out_i), longint'(ei));
    endtask

    task automatic idle_check();
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "idle out_valid", longint'(out_valid), 0);
    endtask

    function automatic int pat_i(input int d, input int r);
        if (d == 20) return -32768;
        return d * 997 - 15000 + r;
    endfunction

    function automatic int pat_q(input int d, input int r);
        if (d == 20) return 32767;
        return 12000 - d * 611 - r;
    endfunction

    // Full Doppler rows for nrng range bins; cfg switches to mid_w after mid_at samples.
    task automatic run_frame(input int w, input int nrng, input int mid_w,
                             input int mid_at, input string req);
        int cnt = 0;
        int cfg = w;
        for (int r = 0; r < nrng; r++) begin
            for (int d = 0; d < NB; d++) begin
                if (cnt == mid_at) cfg = mid_w;
                send(d, r, pat_i(d, r), pat_q(d, r), cfg, req);
                cnt++;
            end
        end
        idle_check();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0 && out_i == '0 && out_q == '0, "R8", "reset outputs",
              longint'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_w = 0;
    endtask

    task automatic t_pass_before_frame();
        // R8: width is 0 after reset; a nonzero cfg is ignored until frame start (R7).
        send(1, 3, 1234, -4321, 5, "R8");
        send(0, 5, -77, 88, 9, "R7");
        idle_check();
    endtask

    task automatic t_zero_width();
        run_frame(0, 1, 0, 1000, "R3");
    endtask

    task automatic t_narrow();
        run_frame(3, 2, 3, 1000, "R4");
        run_frame(1, 1, 1, 1000, "R5");
        run_frame(15, 1, 15, 1000, "R4");
    endtask

    task automatic t_wide();
        run_frame(16, 1, 16, 1000, "R6");
        run_frame(40, 1, 40, 1000, "R6");
    endtask

    task automatic t_midframe_change();
        // R7: width 2 captured; switching to 10 after five samples must not widen the band.
        run_frame(2, 2, 10, 5, "R7");
        // R7: the next frame start picks up 10.
        run_frame(10, 1, 10, 1000, "R7");
    endtask

    task automatic t_reset_mid();
        send(0, 0, 100, 100, 7, "R4");
        t_reset();
        send(0, 1, 555, -555, 7, "R8");
        idle_check();
    endtask

    initial begin
        t_reset();
        t_pass_before_frame();
        t_zero_width();
        t_narrow();
        t_wide();
        t_midframe_change();
        t_reset_mid();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule